// File: doc/BRIEF.md
# Multilevel Arm PWM with Shoot-Through Count Reduction

This block drives one leg of a single-phase converter built from two arms. Each arm holds N series cells, and N is even. Every system clock the block works out how many cells the upper arm inserts and how many the lower arm inserts. It also produces two shoot-through gate pulses, one for the impedance network feeding each arm. A single up/down counter with a run-time half period H makes a triangle from 0 to H and back to 0. N copies of this triangle, each shifted by a multiple of H, form a level-shifted carrier stack that is centred on zero. Each carrier decides one upper cell and one lower cell. The count for an arm is the number of carriers that lie strictly below that arm's signed reference.

The same triangle also serves as the shoot-through carrier. Each arm has an unsigned shoot-through modulating sample. The arm's pulse is requested while the triangle is above that sample. The pulse is granted only if the arm would otherwise insert at least N/2 cells. While the pulse is granted, the arm's count drops by exactly N/2, so the leg output level does not change.

All four input samples come from outside the block. The block latches them once per carrier period, at the top of the triangle. Producing the sine references and choosing which physical cells to switch belong to other blocks.

Top module: `pst_mlpwm`

## Requirements
- R1: While `rst` is high, and on the clock edges after it is released up to the first carrier peak, `np`, `nn`, `su` and `sn` are all zero.
- R2: The carrier value c counts 0,1,…,H,H−1,…,1,0,1,… with a period of 2H clocks, where H = `half_per`. It starts at 0 on the first edge after reset is released and moves by one on every edge.
- R3: Before any reduction, the upper count is the number of k in 0..N−1 for which `ref_up` > c + (k − N/2)·H, comparing as signed values. When a reference equals a carrier value, that carrier does not insert its cell.
- R4: The lower count follows the same rule using `ref_lo`.
- R5: The four input samples are latched only at the carrier peak, which is the edge where the carrier is rising and c = H. Changes between two peaks have no effect on the outputs until the next peak.
- R6: `su` is high exactly when c > the latched `st_up` and the upper count before reduction is at least N/2. `sn` follows the same rule using `st_lo` and the lower count.
- R7: `np` equals the upper count minus N/2 when `su` is high, and equals the upper count otherwise. `nn` relates to `sn` in the same way.
- R8: Every output is registered. The value seen after an edge is computed from the carrier value and the latched samples as they stood before that edge.
- R9: `np` and `nn` always stay within 0..N. While a shoot-through gate is high, the count for that arm is at most N/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_per | input | CNT_W | Carrier half period H, at least 1; change only while in reset |
| ref_up | input | REF_W | Signed upper-arm reference sample |
| ref_lo | input | REF_W | Signed lower-arm reference sample |
| st_up | input | CNT_W | Upper shoot-through modulating sample |
| st_lo | input | CNT_W | Lower shoot-through modulating sample |
| np | output | $clog2(N+1) | Upper-arm inserted cell count |
| nn | output | $clog2(N+1) | Lower-arm inserted cell count |
| su | output | 1 | Upper shoot-through gate |
| sn | output | 1 | Lower shoot-through gate |

## Verification
The bench builds the block with its defaults: N = 4, 12-bit references and a 10-bit carrier counter. It runs first with H = 8 and then, after a second reset, with an odd H = 5. With N = 4 the stack has four carriers, so both the equal-to-carrier case and the threshold of two cells are reached at every carrier value. References just beyond ±N·H/2 reach the saturated counts of 0 and N. Samples that change several times inside one carrier period exercise the latch-at-peak behaviour. Shoot-through samples of 0 and of H cover pulses that are always requested and pulses that are never requested.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int DEF_CELLS = 4;
    localparam int DEF_REF_W = 12;
    localparam int DEF_CNT_W = 10;

    typedef enum logic {
        DIR_DN = 1'b0,
        DIR_UP = 1'b1
    } dir_e;

    function automatic int half_of(input int n);
        return n / 2;
    endfunction

    function automatic int ext_width(input int ref_w, input int cnt_w);
        return ((ref_w > cnt_w) ? ref_w : cnt_w) + 4;
    endfunction

endpackage

// File: rtl/pst_carrier.sv
module pst_carrier
    import pst_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] half_per,
    output logic [CNT_W-1:0] cnt,
    output logic             peak
);

    dir_e dir_q;

    assign peak = (dir_q == DIR_UP) && (cnt >= half_per);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            dir_q <= DIR_UP;
        end else if (dir_q == DIR_UP) begin
            if (cnt >= half_per) begin
                dir_q <= DIR_DN;
                cnt   <= cnt - CNT_W'(1);
            end else begin
                cnt   <= cnt + CNT_W'(1);
            end
        end else begin
            if (cnt == '0) begin
                dir_q <= DIR_UP;
                cnt   <= CNT_W'(1);
            end else begin
                cnt   <= cnt - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pst_arm_count.sv
module pst_arm_count
    import pst_pkg::*;
#(
    parameter int N     = DEF_CELLS,
    parameter int REF_W = DEF_REF_W,
    parameter int CNT_W = DEF_CNT_W,
    parameter int CW    = $clog2(N + 1)
) (
    input  logic signed [REF_W-1:0] ref_s,
    input  logic        [CNT_W-1:0] cnt,
    input  logic        [CNT_W-1:0] half_per,
    output logic        [CW-1:0]    raw
);

    localparam int EW = ext_width(REF_W, CNT_W);

    logic signed [EW-1:0] ref_x;
    logic signed [EW-1:0] cnt_x;
    logic signed [EW-1:0] h_x;
    logic        [N-1:0]  hit;

    assign ref_x = {{(EW-REF_W){ref_s[REF_W-1]}}, ref_s};
    assign cnt_x = {{(EW-CNT_W){1'b0}}, cnt};
    assign h_x   = {{(EW-CNT_W){1'b0}}, half_per};

    for (genvar k = 0; k < N; k++) begin : g_car
        localparam logic signed [EW-1:0] OFS = EW'(k - half_of(N));
        logic signed [EW-1:0] car;
        assign car    = cnt_x + OFS * h_x;
        assign hit[k] = ref_x > car;
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < N; i++) begin
            raw = raw + CW'(hit[i]);
        end
    end

endmodule

// File: rtl/pst_st_arm.sv
module pst_st_arm
    import pst_pkg::*;
#(
    parameter int N     = DEF_CELLS,
    parameter int CNT_W = DEF_CNT_W,
    parameter int CW    = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    raw,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] st_mod,
    output logic [CW-1:0]    count_q,
    output logic             gate_q
);

    localparam logic [CW-1:0] HALF = CW'(half_of(N));

    logic grant;

    assign grant = (cnt > st_mod) && (raw >= HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            gate_q  <= 1'b0;
        end else begin
            gate_q  <= grant;
            count_q <= grant ? (raw - HALF) : raw;
        end
    end

endmodule

// File: rtl/pst_mlpwm.sv
module pst_mlpwm
    import pst_pkg::*;
#(
    parameter int N     = DEF_CELLS,
    parameter int REF_W = DEF_REF_W,
    parameter int CNT_W = DEF_CNT_W,
    parameter int CW    = $clog2(N + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic        [CNT_W-1:0] half_per,
    input  logic signed [REF_W-1:0] ref_up,
    input  logic signed [REF_W-1:0] ref_lo,
    input  logic        [CNT_W-1:0] st_up,
    input  logic        [CNT_W-1:0] st_lo,
    output logic        [CW-1:0]    np,
    output logic        [CW-1:0]    nn,
    output logic                    su,
    output logic                    sn
);

    localparam logic signed [REF_W-1:0] REF_FLOOR = {1'b1, {(REF_W-1){1'b0}}};

    typedef struct packed {
        logic signed [REF_W-1:0] r_up;
        logic signed [REF_W-1:0] r_lo;
        logic        [CNT_W-1:0] s_up;
        logic        [CNT_W-1:0] s_lo;
    } hold_t;

    hold_t            hold_q;
    logic [CNT_W-1:0] car_cnt;
    logic             car_peak;
    logic [CW-1:0]    raw_up;
    logic [CW-1:0]    raw_lo;

    pst_carrier #(.CNT_W(CNT_W)) u_car (
        .clk      (clk),
        .rst      (rst),
        .half_per (half_per),
        .cnt      (car_cnt),
        .peak     (car_peak)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q.r_up <= REF_FLOOR;
            hold_q.r_lo <= REF_FLOOR;
            hold_q.s_up <= '1;
            hold_q.s_lo <= '1;
        end else if (car_peak) begin
            hold_q.r_up <= ref_up;
            hold_q.r_lo <= ref_lo;
            hold_q.s_up <= st_up;
            hold_q.s_lo <= st_lo;
        end
    end

    pst_arm_count #(.N(N), .REF_W(REF_W), .CNT_W(CNT_W), .CW(CW)) u_cnt_up (
        .ref_s    (hold_q.r_up),
        .cnt      (car_cnt),
        .half_per (half_per),
        .raw      (raw_up)
    );

    pst_arm_count #(.N(N), .REF_W(REF_W), .CNT_W(CNT_W), .CW(CW)) u_cnt_lo (
        .ref_s    (hold_q.r_lo),
        .cnt      (car_cnt),
        .half_per (half_per),
        .raw      (raw_lo)
    );

    pst_st_arm #(.N(N), .CNT_W(CNT_W), .CW(CW)) u_st_up (
        .clk     (clk),
        .rst     (rst),
        .raw     (raw_up),
        .cnt     (car_cnt),
        .st_mod  (hold_q.s_up),
        .count_q (np),
        .gate_q  (su)
    );

    pst_st_arm #(.N(N), .CNT_W(CNT_W), .CW(CW)) u_st_lo (
        .clk     (clk),
        .rst     (rst),
        .raw     (raw_lo),
        .cnt     (car_cnt),
        .st_mod  (hold_q.s_lo),
        .count_q (nn),
        .gate_q  (sn)
    );

endmodule

// File: rtl/pst_mlpwm_chk.sv
module pst_mlpwm_chk #(
    parameter int N     = 4,
    parameter int REF_W = 12,
    parameter int CNT_W = 10,
    parameter int CW    = $clog2(N + 1)
) (
    input logic                    clk,
    input logic                    rst,
    input logic        [CNT_W-1:0] cnt,
    input logic                    peak,
    input logic signed [REF_W-1:0] h_r_up,
    input logic signed [REF_W-1:0] h_r_lo,
    input logic        [CNT_W-1:0] h_s_up,
    input logic        [CNT_W-1:0] h_s_lo,
    input logic        [CW-1:0]    raw_up,
    input logic        [CW-1:0]    raw_lo,
    input logic        [CW-1:0]    np,
    input logic        [CW-1:0]    nn,
    input logic                    su,
    input logic                    sn
);

    localparam logic [CW-1:0] HALF = CW'(N / 2);
    localparam logic [CW-1:0] FULL = CW'(N);

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (np == '0 && nn == '0 && !su && !sn)); // R1

    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt == $past(cnt) + CNT_W'(1) || cnt + CNT_W'(1) == $past(cnt))); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !peak |=> ($stable(h_r_up) && $stable(h_r_lo) && $stable(h_s_up) && $stable(h_s_lo))); // R5

    AST_SU_CARRIER: assert property (@(posedge clk) disable iff (rst) (cnt <= h_s_up) |=> !su); // R6

    AST_SN_CARRIER: assert property (@(posedge clk) disable iff (rst) (cnt <= h_s_lo) |=> !sn); // R6

    AST_SU_BLOCKED: assert property (@(posedge clk) disable iff (rst) (raw_up < HALF) |=> !su); // R6

    AST_SN_BLOCKED: assert property (@(posedge clk) disable iff (rst) (raw_lo < HALF) |=> !sn); // R6

    AST_SU_REDUCED: assert property (@(posedge clk) disable iff (rst) su |-> (np <= HALF)); // R7

    AST_SN_REDUCED: assert property (@(posedge clk) disable iff (rst) sn |-> (nn <= HALF)); // R7

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst) (np <= FULL && nn <= FULL)); // R9

endmodule

bind pst_mlpwm pst_mlpwm_chk #(.N(N), .REF_W(REF_W), .CNT_W(CNT_W), .CW(CW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt    (car_cnt),
    .peak   (car_peak),
    .h_r_up (hold_q.r_up),
    .h_r_lo (hold_q.r_lo),
    .h_s_up (hold_q.s_up),
    .h_s_lo (hold_q.s_lo),
    .raw_up (raw_up),
    .raw_lo (raw_lo),
    .np     (np),
    .nn     (nn),
    .su     (su),
    .sn     (sn)
);

// File: tb/pst_mlpwm_tb.sv
module pst_mlpwm_tb;

    localparam int N     = 4;
    localparam int REF_W = 12;
    localparam int CNT_W = 10;
    localparam int CW    = $clog2(N + 1);

    typedef struct {
        int np;
        int nn;
        int su;
        int sn;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic        [CNT_W-1:0] half_per = CNT_W'(8);
    logic signed [REF_W-1:0] ref_up = '0;
    logic signed [REF_W-1:0] ref_lo = '0;
    logic        [CNT_W-1:0] st_up = '0;
    logic        [CNT_W-1:0] st_lo = '0;
    logic        [CW-1:0]    np;
    logic        [CW-1:0]    nn;
    logic                    su;
    logic                    sn;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    exp_t sb_q[$];

    int   m_k;
    int   m_rup, m_rlo, m_sup, m_slo;

    always #4 clk = ~clk;

    pst_mlpwm #(.N(N), .REF_W(REF_W), .CNT_W(CNT_W)) u_dut (
        .clk, .rst, .half_per, .ref_up, .ref_lo, .st_up, .st_lo,
        .np, .nn, .su, .sn
    );

    function automatic int raw_of(input int r, input int c, input int h);
        int n = 0;
        for (int k = 0; k < N; k++) begin
            if (r > c + (k - N / 2) * h) n++;
        end
        return n;
    endfunction

    // reference model from R2..R8, pushes one expected item per clock
    always @(posedge clk) begin
        if (rst) begin
            m_k   = 0;
            m_rup = -(1 << (REF_W - 1));
            m_rlo = -(1 << (REF_W - 1));
            m_sup = (1 << CNT_W) - 1;
            m_slo = (1 << CNT_W) - 1;
        end else begin
            int   h, ph, c, ru, rl;
            exp_t e;
            h  = int'(half_per);
            ph = m_k % (2 * h);
            c  = (ph <= h) ? ph : 2 * h - ph;
            ru = raw_of(m_rup, c, h);
            rl = raw_of(m_rlo, c, h);
            e.su = (c > m_sup && ru >= N / 2) ? 1 : 0;
            e.sn = (c > m_slo && rl >= N / 2) ? 1 : 0;
            e.np = (e.su != 0) ? ru - N / 2 : ru;
            e.nn = (e.sn != 0) ? rl - N / 2 : rl;
            sb_q.push_back(e);
            if (ph == h) begin
                m_rup = int'(ref_up);
                m_rlo = int'(ref_lo);
                m_sup = int'(st_up);
                m_slo = int'(st_lo);
            end
            m_k++;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            bit   bad;
            e   = sb_q.pop_front();
            bad = 0;
            n_tests++;
            if (int'(np) != e.np) begin
                bad = 1;
                $display("FAIL R3/R2/R7/R8 np got %0d expected %0d", np, e.np);
            end
            if (int'(nn) != e.nn) begin
                bad = 1;
                $display("FAIL R4/R7 nn got %0d expected %0d", nn, e.nn);
            end
            if (int'(su) != e.su) begin
                bad = 1;
                $display("FAIL R6/R5 su got %0d expected %0d", su, e.su);
            end
            if (int'(sn) != e.sn) begin
                bad = 1;
                $display("FAIL R6/R5 sn got %0d expected %0d", sn, e.sn);
            end
            if (bad) n_fail++;
        end
    end

    task automatic check_zero(input string tag);
        n_tests++;
        if (np != '0 || nn != '0 || su || sn) begin
            n_fail++;
            $display("FAIL R1 %s outputs got %0d/%0d/%0d/%0d expected 0/0/0/0", tag, np, nn, su, sn);
        end
    endtask

    task automatic do_reset(input int h);
        @(negedge clk);
        rst      = 1'b1;
        half_per = CNT_W'(h);
        repeat (3) @(negedge clk);
        check_zero("in reset");
        rst = 1'b0;
    endtask

    task automatic drive(input int ru, input int rl, input int s_u, input int s_l, input int cyc);
        @(negedge clk);
        ref_up = REF_W'(ru);
        ref_lo = REF_W'(rl);
        st_up  = CNT_W'(s_u);
        st_lo  = CNT_W'(s_l);
        repeat (cyc - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        ref_up = REF_W'(100);
        ref_lo = REF_W'(100);
        do_reset(8);
        // R1: before the first peak latches samples, outputs stay zero
        repeat (4) @(negedge clk);
        check_zero("before first peak");
        // R3 R4: balanced references, no shoot-through, equality at c=H
        drive(0, 0, 8, 8, 40);
        drive(8, -8, 8, 8, 40);
        // R9: saturation beyond the carrier stack
        drive(17, -17, 8, 8, 40);
        drive(-100, 100, 8, 8, 40);
        // R6 R7: shoot-through always requested, granted only with enough cells
        drive(16, -16, 0, 0, 40);
        drive(-16, 16, 3, 5, 40);
        drive(4, -4, 2, 6, 40);
        drive(0, 0, 4, 4, 40);
        // R5: samples change inside a period, only peak values matter
        for (int i = 0; i < 12; i++) begin
            drive((i * 7) % 33 - 16, 16 - (i * 5) % 33, i % 9, (i + 4) % 9, 3);
        end
        drive(0, 0, 8, 8, 20);
        // R2: odd half period after a fresh reset
        do_reset(5);
        repeat (2) @(negedge clk);
        check_zero("after second reset");
        drive(3, -3, 8, 8, 30);
        drive(5, -5, 1, 2, 30);
        drive(10, -10, 0, 0, 30);
        drive(-7, 7, 2, 0, 30);
        repeat (4) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule